// File: doc/BRIEF.md
# Sectored Read Cache Controller

This block is a direct-mapped read cache whose storage is organised as sectors. Each sector keeps a single address tag, and is split into several subsectors that each carry their own valid bit. A sector may therefore be only partly filled: some of its subsectors hit while others still miss under the same tag. The memory side always moves exactly one subsector per fetch, so a miss never costs a whole-sector refill.

A processor issues word reads through a request port with a valid/ready handshake. On a hit the word comes back one cycle later. On a miss the controller stops accepting requests and fetches the missing subsector over a memory request/response channel. It writes the subsector into storage and then returns the word, marked as a miss. If the tag of the indexed sector differs from the request, that sector is evicted: all of its valid bits are cleared, the new tag is written and only the requested subsector is brought in. The sector count, subsectors per sector, words per subsector and the data and address widths are parameters, and the address fields are derived from them. Each of these counts must be a power of two and at least 2.

Top module: `sect_cache`

## Requirements
- R1: After reset every subsector is invalid. `cpu_ready` is 1 and both `cpu_rsp_valid` and `mem_req_valid` are 0, so the first read of any address misses.
- R2: A read hits only when the stored tag of the indexed sector equals the request tag and the addressed subsector is valid. A hit returns `cpu_rsp_valid`=1, `cpu_rsp_hit`=1 and the stored word in the cycle after acceptance, and it issues no memory request.
- R3: A miss issues exactly one memory request. Its address is the request address with the word-offset bits (the lowest log2(WORDS_PER_SUB) bits) forced to zero, and the response carries that subsector's words with word 0 in the least significant DATA_W bits.
- R4: A miss whose tag differs from the indexed sector's tag evicts the sector. All its subsectors become invalid and the new tag is stored, so later reads of the old tag miss and other subsectors under the new tag miss until they are fetched.
- R5: A miss whose tag matches but whose subsector is invalid fetches only that subsector. Subsectors that were already valid in that sector keep hitting with unchanged data.
- R6: From the cycle after a miss is accepted until its fill is written, `cpu_ready` is 0. At most one memory fetch is outstanding.
- R7: `mem_req_valid` and `mem_req_addr` stay stable until `mem_req_ready` is seen.
- R8: The cycle after the memory response is taken, the controller returns `cpu_rsp_valid`=1, `cpu_rsp_hit`=0 and the requested word from the fetched subsector, with `cpu_ready` already 1 again.
- R9: The address is read as {tag, sector index, subsector index, word offset} from most to least significant. Sectors with different indices are independent, and the word offset selects the word within a subsector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | Processor read request present |
| cpu_req_addr | input | ADDR_W | Word address of the read |
| cpu_ready | output | 1 | Controller can accept a request this cycle |
| cpu_rsp_valid | output | 1 | Read response present (one cycle) |
| cpu_rsp_hit | output | 1 | Response was served from the cache |
| cpu_rsp_data | output | DATA_W | Read word |
| mem_req_valid | output | 1 | Subsector fetch request |
| mem_req_ready | input | 1 | Memory accepts the fetch request |
| mem_req_addr | output | ADDR_W | Subsector-aligned fetch address |
| mem_rsp_valid | input | 1 | Fetched subsector present |
| mem_rsp_data | input | WORDS_PER_SUB*DATA_W | Fetched subsector words |

## Verification
The bound checker enforces the handshake rules on every cycle. These are: a held and stable memory request, a subsector-aligned fetch address, ready withdrawn while a fetch is pending, a single outstanding fetch, one-cycle hit latency, and a miss response that directly follows the fill. Whether a given read should hit at all depends on the history of tags and valid bits, so only the directed scenarios can show it. These cover a cold miss, hits on other words, a partial-sector fill, eviction that clears sibling subsectors, independence of sector indices and a stalled memory.

// File: rtl/sect_cache_pkg.sv
// Shared types for the sectored read cache.
package sect_cache_pkg;
    // Fill sequencer states.
    typedef enum logic [1:0] {
        FILL_IDLE = 2'd0,
        FILL_REQ  = 2'd1,
        FILL_WAIT = 2'd2
    } fill_state_t;
endpackage

// File: rtl/sect_tag_store.sv
// Per-sector tag and per-subsector valid bits.
// Lookup is combinational. An allocate rewrites a sector's tag and clears
// all its valid bits. A fill sets one valid bit.
// Assumes allocate and fill never target the same cycle (the fill sequencer
// serialises them).
module sect_tag_store #(
    parameter int NUM_SECTORS = 8,
    parameter int SUBS        = 4,
    parameter int TAG_W       = 10,
    localparam int IDX_W      = $clog2(NUM_SECTORS),
    localparam int SUB_W      = $clog2(SUBS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [SUB_W-1:0] lk_sub,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             tag_match,
    output logic             sub_valid,
    input  logic             alloc_en,
    input  logic [IDX_W-1:0] alloc_idx,
    input  logic [TAG_W-1:0] alloc_tag,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [SUB_W-1:0] fill_sub
);
    logic [TAG_W-1:0] tag_q   [NUM_SECTORS];
    logic [SUBS-1:0]  valid_q [NUM_SECTORS];

    // Update tags and valid bits on reset, allocation and fill.
    always_ff @(posedge clk) begin
        for (int s = 0; s < NUM_SECTORS; s++) begin
            if (!rst_n) begin
                tag_q[s]   <= '0;
                valid_q[s] <= '0;
            end else if (alloc_en && alloc_idx == IDX_W'(s)) begin
                tag_q[s]   <= alloc_tag;
                valid_q[s] <= '0;
            end else if (fill_en && fill_idx == IDX_W'(s)) begin
                valid_q[s][fill_sub] <= 1'b1;
            end
        end
    end

    // Combinational lookup for the incoming request.
    always_comb begin
        tag_match = (tag_q[lk_idx] == lk_tag);
        sub_valid = valid_q[lk_idx][lk_sub];
    end
endmodule

// File: rtl/sect_data_store.sv
// Data array holding one subsector-wide line per (sector, subsector) pair.
// Read is combinational, write is a full line. Contents are not reset, and
// validity is tracked by the tag store.
module sect_data_store #(
    parameter int NUM_LINES = 32,
    parameter int LINE_W    = 64,
    localparam int PTR_W    = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic [PTR_W-1:0]  rd_ptr,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [LINE_W-1:0] wr_line
);
    logic [LINE_W-1:0] mem_q [NUM_LINES];

    // Write a fetched subsector.
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_ptr] <= wr_line;
    end

    // Read the line addressed by the current request.
    assign rd_line = mem_q[rd_ptr];
endmodule

// File: rtl/sect_fill_ctrl.sv
// Miss sequencer: latches the missing address, raises one memory request,
// waits for the response and signals the fill. Only one fetch in flight.
// Assumes the memory answers every accepted request exactly once.
module sect_fill_ctrl
    import sect_cache_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_fire,
    input  logic              req_hit,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    output logic              ctrl_idle,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic              fill_en,
    output logic [ADDR_W-1:0] miss_addr
);
    fill_state_t       state_q;
    logic [ADDR_W-1:0] miss_addr_q;

    // Advance the miss sequence and hold the missing address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= FILL_IDLE;
            miss_addr_q <= '0;
        end else begin
            case (state_q)
                FILL_IDLE: if (req_fire && !req_hit) begin
                    miss_addr_q <= req_addr;
                    state_q     <= FILL_REQ;
                end
                FILL_REQ:  if (mem_req_ready) state_q <= FILL_WAIT;
                FILL_WAIT: if (mem_rsp_valid) state_q <= FILL_IDLE;
                default:   state_q <= FILL_IDLE;
            endcase
        end
    end

    // Decode outputs from the state.
    always_comb begin
        ctrl_idle     = (state_q == FILL_IDLE);
        mem_req_valid = (state_q == FILL_REQ);
        fill_en       = (state_q == FILL_WAIT) && mem_rsp_valid;
        mem_req_addr  = {miss_addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        miss_addr     = miss_addr_q;
    end
endmodule

// File: rtl/sect_cache.sv
// Sectored direct-mapped read cache. One tag per sector, one valid bit per
// subsector, fills of a single subsector per miss.
// Assumes all count parameters are powers of two and at least 2.
module sect_cache #(
    parameter int ADDR_W          = 16,
    parameter int DATA_W          = 32,
    parameter int NUM_SECTORS     = 8,
    parameter int SUBS_PER_SECTOR = 4,
    parameter int WORDS_PER_SUB   = 2,
    localparam int OFF_W  = $clog2(WORDS_PER_SUB),
    localparam int SUB_W  = $clog2(SUBS_PER_SECTOR),
    localparam int IDX_W  = $clog2(NUM_SECTORS),
    localparam int TAG_W  = ADDR_W - IDX_W - SUB_W - OFF_W,
    localparam int PTR_W  = IDX_W + SUB_W,
    localparam int LINE_W = WORDS_PER_SUB * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    output logic              cpu_ready,
    output logic              cpu_rsp_valid,
    output logic              cpu_rsp_hit,
    output logic [DATA_W-1:0] cpu_rsp_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [LINE_W-1:0] mem_rsp_data
);
    logic              ctrl_idle, req_fire, tag_match, sub_valid, req_hit;
    logic              alloc_en, fill_en;
    logic [ADDR_W-1:0] miss_addr;
    logic [LINE_W-1:0] rd_line;

    // Request field decode and hit decision.
    assign cpu_ready = ctrl_idle;
    assign req_fire  = cpu_req_valid && ctrl_idle;
    assign req_hit   = tag_match && sub_valid;
    assign alloc_en  = req_fire && !tag_match;

    sect_tag_store #(
        .NUM_SECTORS (NUM_SECTORS),
        .SUBS        (SUBS_PER_SECTOR),
        .TAG_W       (TAG_W)
    ) tags_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_idx    (cpu_req_addr[OFF_W+SUB_W +: IDX_W]),
        .lk_sub    (cpu_req_addr[OFF_W +: SUB_W]),
        .lk_tag    (cpu_req_addr[ADDR_W-1 -: TAG_W]),
        .tag_match (tag_match),
        .sub_valid (sub_valid),
        .alloc_en  (alloc_en),
        .alloc_idx (cpu_req_addr[OFF_W+SUB_W +: IDX_W]),
        .alloc_tag (cpu_req_addr[ADDR_W-1 -: TAG_W]),
        .fill_en   (fill_en),
        .fill_idx  (miss_addr[OFF_W+SUB_W +: IDX_W]),
        .fill_sub  (miss_addr[OFF_W +: SUB_W])
    );

    sect_data_store #(
        .NUM_LINES (NUM_SECTORS * SUBS_PER_SECTOR),
        .LINE_W    (LINE_W)
    ) data_i (
        .clk     (clk),
        .rd_ptr  (cpu_req_addr[OFF_W +: PTR_W]),
        .rd_line (rd_line),
        .wr_en   (fill_en),
        .wr_ptr  (miss_addr[OFF_W +: PTR_W]),
        .wr_line (mem_rsp_data)
    );

    sect_fill_ctrl #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W)
    ) fill_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_fire      (req_fire),
        .req_hit       (req_hit),
        .req_addr      (cpu_req_addr),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .ctrl_idle     (ctrl_idle),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .fill_en       (fill_en),
        .miss_addr     (miss_addr)
    );

    // Register the response: a hit word, or the missed word from the fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_rsp_valid <= 1'b0;
            cpu_rsp_hit   <= 1'b0;
            cpu_rsp_data  <= '0;
        end else begin
            cpu_rsp_valid <= (req_fire && req_hit) || fill_en;
            cpu_rsp_hit   <= req_fire && req_hit;
            if (fill_en)
                cpu_rsp_data <= mem_rsp_data[miss_addr[OFF_W-1:0]*DATA_W +: DATA_W];
            else if (req_fire && req_hit)
                cpu_rsp_data <= rd_line[cpu_req_addr[OFF_W-1:0]*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/sect_cache_chk.sv
// Protocol checker for sect_cache, attached with bind.
// Tracks whether a memory fetch is in flight and checks the handshake
// and response timing rules.
module sect_cache_chk #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req_valid,
    input logic              cpu_ready,
    input logic              cpu_rsp_valid,
    input logic              cpu_rsp_hit,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid
);
    logic pend_q;

    // Track an accepted but unanswered memory fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)                             pend_q <= 1'b0;
        else if (mem_req_valid && mem_req_ready) pend_q <= 1'b1;
        else if (mem_rsp_valid)                  pend_q <= 1'b0;
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R7
    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[OFF_W-1:0] == '0); // R3
    AST_NOT_READY_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || pend_q) |-> !cpu_ready); // R6
    AST_SINGLE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !pend_q); // R6
    AST_HIT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rsp_valid && cpu_rsp_hit |-> $past(cpu_req_valid && cpu_ready)); // R2
    AST_MISS_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rsp_valid && !cpu_rsp_hit |-> $past(mem_rsp_valid && pend_q)); // R8
    AST_READY_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid && pend_q |=> cpu_ready && cpu_rsp_valid); // R8
endmodule

bind sect_cache sect_cache_chk #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_valid (cpu_req_valid),
    .cpu_ready     (cpu_ready),
    .cpu_rsp_valid (cpu_rsp_valid),
    .cpu_rsp_hit   (cpu_rsp_hit),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/sect_cache_tb_top.sv
`timescale 1ns/1ps
// Directed bench for sect_cache: one task per scenario, memory modelled
// with programmable stall and latency.
module sect_cache_tb_top;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int WORDS  = 2;
    localparam int LINE_W = WORDS * DATA_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_req_valid = 1'b0;
    logic [ADDR_W-1:0] cpu_req_addr = '0;
    logic              cpu_ready, cpu_rsp_valid, cpu_rsp_hit;
    logic [DATA_W-1:0] cpu_rsp_data;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b0;
    logic [ADDR_W-1:0] mem_req_addr;
    logic              mem_rsp_valid = 1'b0;
    logic [LINE_W-1:0] mem_rsp_data = '0;

    int checks = 0;
    int errors = 0;
    int req_count = 0;
    int stall_cyc = 0;
    int lat_cyc = 1;
    logic [ADDR_W-1:0] last_req_addr = '0;

    always #2 clk = ~clk;

    sect_cache dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_addr(cpu_req_addr),
        .cpu_ready(cpu_ready), .cpu_rsp_valid(cpu_rsp_valid),
        .cpu_rsp_hit(cpu_rsp_hit), .cpu_rsp_data(cpu_rsp_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    // Address layout: {tag[9:0], index[2:0], sub[1:0], offset[0]}.
    function automatic logic [ADDR_W-1:0] mk(int tag, int idx, int sub, int off);
        return {tag[9:0], idx[2:0], sub[1:0], off[0]};
    endfunction

    function automatic logic [DATA_W-1:0] word_of(logic [ADDR_W-1:0] a);
        return {~a, a};
    endfunction

    function automatic logic [LINE_W-1:0] line_of(logic [ADDR_W-1:0] a);
        logic [LINE_W-1:0] l;
        for (int w = 0; w < WORDS; w++) l[w*DATA_W +: DATA_W] = word_of(a + ADDR_W'(w));
        return l;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Memory model: accepts one request, optional stall, then answers.
    initial begin
        logic [ADDR_W-1:0] a;
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                repeat (stall_cyc) @(negedge clk);
                a = mem_req_addr;
                last_req_addr = a;
                req_count++;
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                repeat (lat_cyc) @(negedge clk);
                mem_rsp_data  = line_of(a);
                mem_rsp_valid = 1'b1;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    // Issue one read and check hit/miss, data, timing and fetch traffic.
    task automatic read_chk(logic [ADDR_W-1:0] a, bit exp_hit, string req);
        int rc0, cyc;
        bit rdy_after;
        while (!cpu_ready) @(negedge clk);
        rc0 = req_count;
        cpu_req_valid = 1'b1;
        cpu_req_addr  = a;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        rdy_after = cpu_ready;
        cyc = 0;
        while (!cpu_rsp_valid && cyc < 60) begin
            @(negedge clk);
            cyc++;
        end
        check(cpu_rsp_valid == 1'b1, req, "response seen", cpu_rsp_valid, 1);
        check(cpu_rsp_hit == exp_hit, req, "hit flag", cpu_rsp_hit, exp_hit);
        check(cpu_rsp_data == word_of(a), req, "data", cpu_rsp_data, word_of(a));
        if (exp_hit) begin
            check(cyc == 0, req, "hit latency (R2)", cyc, 0);
            check(req_count == rc0, req, "no fetch on hit (R2)", req_count, rc0);
        end else begin
            check(req_count == rc0 + 1, req, "single fetch (R3)", req_count, rc0 + 1);
            check(last_req_addr == {a[ADDR_W-1:1], 1'b0}, req, "fetch address (R3)",
                  last_req_addr, {a[ADDR_W-1:1], 1'b0});
            check(rdy_after == 1'b0, req, "ready low during fill (R6)", rdy_after, 0);
            check(cpu_ready == 1'b1, req, "ready back with response (R8)", cpu_ready, 1);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cpu_ready == 1'b1, "R1", "ready after reset", cpu_ready, 1);
        check(cpu_rsp_valid == 1'b0, "R1", "no response after reset", cpu_rsp_valid, 0);
        check(mem_req_valid == 1'b0, "R1", "no fetch after reset", mem_req_valid, 0);
        read_chk(mk(1, 0, 0, 0), 1'b0, "R1");
    endtask

    task automatic t_hits();
        read_chk(mk(1, 0, 0, 1), 1'b1, "R9");
        read_chk(mk(1, 0, 0, 0), 1'b1, "R2");
    endtask

    task automatic t_partial();
        read_chk(mk(1, 0, 2, 1), 1'b0, "R5");
        read_chk(mk(1, 0, 0, 0), 1'b1, "R5");
        read_chk(mk(1, 0, 2, 0), 1'b1, "R5");
    endtask

    task automatic t_evict();
        read_chk(mk(5, 0, 1, 0), 1'b0, "R4");
        read_chk(mk(5, 0, 0, 0), 1'b0, "R4");
        read_chk(mk(1, 0, 2, 0), 1'b0, "R4");
        read_chk(mk(1, 0, 0, 0), 1'b0, "R4");
        read_chk(mk(1, 0, 2, 1), 1'b1, "R4");
    endtask

    task automatic t_stall();
        stall_cyc = 3;
        lat_cyc   = 4;
        read_chk(mk(2, 3, 3, 1), 1'b0, "R7");
        stall_cyc = 0;
        lat_cyc   = 1;
        read_chk(mk(1, 0, 0, 1), 1'b1, "R9");
        read_chk(mk(2, 3, 3, 0), 1'b1, "R9");
        read_chk(mk(2, 4, 3, 0), 1'b0, "R6");
    endtask

    initial begin
        t_reset();
        t_hits();
        t_partial();
        t_evict();
        t_stall();
        repeat (2) @(negedge clk);
        finish_run();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end
endmodule